// File: doc/BRIEF.md
# Channel Matrix with Soft Mute

This block sits in a per-sample stereo audio path. It builds each of the two output channels from the pair of signed input samples. An output channel can carry the left input, the right input, or the arithmetic mean of both, and a 2-bit code picks the source for each channel. The code value 00 asks for silence. Silence is reached through a gradual gain ramp that follows a raised-cosine curve, so the audio is never cut off abruptly.

The ramp has 32 gain steps. Step 0 is unity. Steps 1 to 31 come from a cosine table, and a final step 32 is exact zero. Each step stays in force for a fixed number of sample strobes, 32 by default. When the mute is released, the ramp runs back through the same steps in the opposite order. If the mute request changes direction partway through a ramp, the ramp turns around at its current step and does not start over.

A mode input chooses between two control sources. In register mode the two codes set routing and mute. In pin mode routing is fixed to straight through, the codes are ignored, and one dedicated pin per channel requests the mute. All state changes take place on sample strobes, so every sample is processed whole.

Top module: `chan_mute_matrix`

## Requirements
- R1: In register mode, each channel's 2-bit code selects its source: 01 gives the right input, 10 gives the left input, 11 gives the mean of both, and 00 requests mute. The mean is the 21-bit sum of the two sign-extended inputs shifted right arithmetically by one, which rounds toward minus infinity.
- R2: The outputs are registered. `smp_vld_o` goes high exactly one clock after each cycle in which `smp_vld_i` is high. The sample outputs stay stable after any cycle without a strobe.
- R3: At ramp step 0 (full level), the output equals the selected source sample bit for bit.
- R4: Each ramp step stays in force for HOLD_LEN (32) strobes before the ramp moves to the next step. Step k, for k from 1 to 31, uses gain g = round(65536·0.5·(1+cos(πk/32))). The output is floor((s·g + 32768)/65536).
- R5: After 32·HOLD_LEN (1024) consecutive muted strobes, the ramp reaches step 32. From then on the channel outputs exactly zero for as long as the mute holds.
- R6: On release, the ramp steps back toward step 0 at the same rate of one step per HOLD_LEN strobes. It reaches unity after the same number of strobes that the descent took.
- R7: A reversal of the mute request turns the ramp around at its current step. The hold count restarts on that reversal, so the first step change comes HOLD_LEN strobes after it.
- R8: Cycles without a strobe change neither the ramp state nor the outputs.
- R9: In pin mode, the left output always carries the left input and the right output always carries the right input, and the 2-bit codes have no effect. `pin_mute_l_i` ramps only the left channel and `pin_mute_r_i` ramps only the right channel.
- R10: While a channel's code is 00, the channel keeps ramping the source that its last non-mute code selected. After reset, or while in pin mode, that remembered source is the straight-through input.
- R11: While reset is asserted, the outputs are zero, `smp_vld_o` is low, and both ramps sit at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Input sample strobe |
| smp_l_i | input | 20 | Left input sample, two's complement |
| smp_r_i | input | 20 | Right input sample, two's complement |
| code_l_i | input | 2 | Left output routing code (register mode) |
| code_r_i | input | 2 | Right output routing code (register mode) |
| reg_mode_i | input | 1 | 1 selects register mode, 0 selects pin mode |
| pin_mute_l_i | input | 1 | Left mute request in pin mode |
| pin_mute_r_i | input | 1 | Right mute request in pin mode |
| smp_vld_o | output | 1 | Output sample strobe |
| smp_l_o | output | 20 | Left output sample |
| smp_r_o | output | 20 | Right output sample |

## Verification
The routing matrix is first run through all sixteen pairs of codes. The samples are pseudo-random, and a set of extreme pairs (both at full positive scale, both at full negative scale, and pairs whose sum is odd and negative) separates the mean's rounding and overflow behaviour from a plain wrong source. Sparse strobes show whether the ramp or the output registers ever advance between samples. A full 1024-strobe descent, a hold at silence and a full ascent check every table gain and the reverse order. A release after 100 strobes and a re-mute partway up show whether a reversal resumes from the current step or wrongly restarts. Pin mode is driven with codes of 00 applied while one pin at a time mutes its channel, which reveals any leakage of the codes or any cross-coupling between the two channels.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int GAIN_W   = 16;
  localparam int STEP_CNT = 32;
  localparam int STEP_W   = $clog2(STEP_CNT + 1);

  typedef enum logic [1:0] {
    ROUTE_MUTE  = 2'b00,
    ROUTE_RIGHT = 2'b01,
    ROUTE_LEFT  = 2'b10,
    ROUTE_MIX   = 2'b11
  } route_e;
endpackage

// File: rtl/cmx_gain_rom.sv
module cmx_gain_rom
  import cmx_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              unity_o,
  output logic              zero_o
);
  int unsigned k;

  always_comb begin
    k = int'(step_i);
    case (k)
      1:  gain_o = 16'd65378;
      2:  gain_o = 16'd64906;
      3:  gain_o = 16'd64125;
      4:  gain_o = 16'd63042;
      5:  gain_o = 16'd61667;
      6:  gain_o = 16'd60014;
      7:  gain_o = 16'd58098;
      8:  gain_o = 16'd55938;
      9:  gain_o = 16'd53556;
      10: gain_o = 16'd50973;
      11: gain_o = 16'd48215;
      12: gain_o = 16'd45308;
      13: gain_o = 16'd42280;
      14: gain_o = 16'd39161;
      15: gain_o = 16'd35980;
      16: gain_o = 16'd32768;
      17: gain_o = 16'd29556;
      18: gain_o = 16'd26375;
      19: gain_o = 16'd23256;
      20: gain_o = 16'd20228;
      21: gain_o = 16'd17321;
      22: gain_o = 16'd14563;
      23: gain_o = 16'd11980;
      24: gain_o = 16'd9598;
      25: gain_o = 16'd7438;
      26: gain_o = 16'd5522;
      27: gain_o = 16'd3869;
      28: gain_o = 16'd2494;
      29: gain_o = 16'd1411;
      30: gain_o = 16'd630;
      31: gain_o = 16'd158;
      default: gain_o = '0;
    endcase
  end

  assign unity_o = (step_i == '0);
  assign zero_o  = (step_i >= STEP_W'(STEP_CNT));
endmodule

// File: rtl/cmx_ramp_ctl.sv
module cmx_ramp_ctl
  import cmx_pkg::*;
#(
  parameter int HOLD_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic              mute_i,
  output logic [STEP_W-1:0] step_o
);
  localparam int HOLD_W = (HOLD_LEN > 1) ? $clog2(HOLD_LEN) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_LEN - 1);
  localparam logic [STEP_W-1:0] STEP_END  = STEP_W'(STEP_CNT);

  logic [STEP_W-1:0] step_q, step_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d, cnt_base;
  logic              dir_q, dir_d;
  logic              moving;

  assign cnt_base = (mute_i != dir_q) ? '0 : cnt_q;
  assign moving   = mute_i ? (step_q != STEP_END) : (step_q != '0);

  always_comb begin
    step_d = step_q;
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    if (stb_i) begin
      dir_d = mute_i;
      if (!moving) begin
        cnt_d = '0;
      end else if (cnt_base == HOLD_LAST) begin
        cnt_d  = '0;
        step_d = mute_i ? (step_q + 1'b1) : (step_q - 1'b1);
      end else begin
        cnt_d = cnt_base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
    end
  end

  assign step_o = step_q;

  // R8
  step_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(step_q));

  // R4
  step_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> (step_q == $past(step_q)) || (step_q == $past(step_q) + 1'b1) ||
              (step_q + 1'b1 == $past(step_q)));

  // R5
  mute_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && mute_i) |=> step_q >= $past(step_q));

  // R6
  release_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !mute_i) |=> step_q <= $past(step_q));
endmodule

// File: rtl/cmx_scale.sv
module cmx_scale
  import cmx_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic        [GAIN_W-1:0] gain_i,
  input  logic                     unity_i,
  input  logic                     zero_i,
  output logic        [DATA_W-1:0] scaled_o
);
  localparam int PW = DATA_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] RND = PW'(2 ** (GAIN_W - 1));

  logic signed [PW-1:0] s_ext, g_ext, prod, rnd;

  always_comb begin
    s_ext = PW'(sample_i);
    g_ext = PW'($signed({1'b0, gain_i}));
    prod  = s_ext * g_ext;
    rnd   = prod + RND;
    if (unity_i) begin
      scaled_o = sample_i;
    end else if (zero_i) begin
      scaled_o = '0;
    end else begin
      scaled_o = rnd[GAIN_W +: DATA_W];
    end
  end
endmodule

// File: rtl/chan_mute_matrix.sv
module chan_mute_matrix
  import cmx_pkg::*;
#(
  parameter int DATA_W   = 20,
  parameter int HOLD_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] smp_l_i,
  input  logic [DATA_W-1:0] smp_r_i,
  input  logic [1:0]        code_l_i,
  input  logic [1:0]        code_r_i,
  input  logic              reg_mode_i,
  input  logic              pin_mute_l_i,
  input  logic              pin_mute_r_i,
  output logic              smp_vld_o,
  output logic [DATA_W-1:0] smp_l_o,
  output logic [DATA_W-1:0] smp_r_o
);
  localparam int NCH = 2;

  logic [1:0]               code_in [NCH];
  logic                     pin_in  [NCH];
  logic signed [DATA_W:0]   sum_w;
  logic [DATA_W-1:0]        mix_w;
  logic                     vld_q;

  assign code_in[0] = code_l_i;
  assign code_in[1] = code_r_i;
  assign pin_in[0]  = pin_mute_l_i;
  assign pin_in[1]  = pin_mute_r_i;

  assign sum_w = $signed({smp_l_i[DATA_W-1], smp_l_i}) + $signed({smp_r_i[DATA_W-1], smp_r_i});
  assign mix_w = sum_w[DATA_W:1];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam logic [1:0] STRAIGHT = (ch == 0) ? ROUTE_LEFT : ROUTE_RIGHT;

    logic [1:0]        eff_code, sel_code, held_q, held_d;
    logic              mute_req;
    logic [DATA_W-1:0] src_w, scaled_w, chan_d, chan_q;
    logic [GAIN_W-1:0] gain_w;
    logic              unity_w, zero_w;
    logic [STEP_W-1:0] step_w;

    always_comb begin
      eff_code = reg_mode_i ? code_in[ch] : STRAIGHT;
      mute_req = reg_mode_i ? (code_in[ch] == ROUTE_MUTE) : pin_in[ch];
      sel_code = (eff_code == ROUTE_MUTE) ? held_q : eff_code;
      held_d   = held_q;
      if (smp_vld_i && (eff_code != ROUTE_MUTE)) begin
        held_d = eff_code;
      end
    end

    always_comb begin
      case (sel_code)
        ROUTE_RIGHT: src_w = smp_r_i;
        ROUTE_LEFT:  src_w = smp_l_i;
        ROUTE_MIX:   src_w = mix_w;
        default:     src_w = '0;
      endcase
    end

    cmx_ramp_ctl #(
      .HOLD_LEN (HOLD_LEN)
    ) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb_i  (smp_vld_i),
      .mute_i (mute_req),
      .step_o (step_w)
    );

    cmx_gain_rom u_rom (
      .step_i  (step_w),
      .gain_o  (gain_w),
      .unity_o (unity_w),
      .zero_o  (zero_w)
    );

    cmx_scale #(
      .DATA_W (DATA_W)
    ) u_scale (
      .sample_i (src_w),
      .gain_i   (gain_w),
      .unity_i  (unity_w),
      .zero_i   (zero_w),
      .scaled_o (scaled_w)
    );

    assign chan_d = smp_vld_i ? scaled_w : chan_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_q <= STRAIGHT;
        chan_q <= '0;
      end else begin
        held_q <= held_d;
        chan_q <= chan_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= smp_vld_i;
    end
  end

  assign smp_vld_o = vld_q;
  assign smp_l_o   = g_chan[0].chan_q;
  assign smp_r_o   = g_chan[1].chan_q;

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld_i |=> smp_vld_o);

  // R2
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i |=> !smp_vld_o);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i |=> ($stable(smp_l_o) && $stable(smp_r_o)));

  // R3
  left_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode_i && smp_vld_i && (code_l_i == ROUTE_LEFT) && (g_chan[0].step_w == '0))
      |=> (smp_l_o == $past(smp_l_i)));

  // R9
  pin_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_mode_i && smp_vld_i && !pin_mute_r_i && (g_chan[1].step_w == '0))
      |=> (smp_r_o == $past(smp_r_i)));

  // R5
  silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && (g_chan[0].step_w == STEP_W'(STEP_CNT))) |=> (smp_l_o == '0));
endmodule

// File: tb/chan_mute_matrix_bench.sv
`timescale 1ns/1ps
module chan_mute_matrix_bench;
  localparam int  DW    = 20;
  localparam int  HOLD  = 32;
  localparam int  NSTEP = 32;
  localparam real PI    = 3.14159265358979;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vld = 1'b0;
  logic [DW-1:0] l_in = '0;
  logic [DW-1:0] r_in = '0;
  logic [1:0]    cl = 2'b10;
  logic [1:0]    cr = 2'b01;
  logic          regm = 1'b1;
  logic          pml = 1'b0;
  logic          pmr = 1'b0;
  logic          vld_o;
  logic [DW-1:0] l_o, r_o;

  always #5 clk = ~clk;

  chan_mute_matrix u_chan_mute_matrix (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_vld_i    (vld),
    .smp_l_i      (l_in),
    .smp_r_i      (r_in),
    .code_l_i     (cl),
    .code_r_i     (cr),
    .reg_mode_i   (regm),
    .pin_mute_l_i (pml),
    .pin_mute_r_i (pmr),
    .smp_vld_o    (vld_o),
    .smp_l_o      (l_o),
    .smp_r_o      (r_o)
  );

  int          vectors = 0;
  int          misses  = 0;
  bit          chk_en  = 1'b0;
  string       tag     = "R11";
  logic [31:0] seed    = 32'h1234_5678;

  bit     m_vld;
  longint m_out  [2];
  int     m_idx  [2];
  int     m_cnt  [2];
  bit     m_dir  [2];
  int     m_held [2];

  function automatic longint gain_of(int k);
    return longint'($rtoi(32768.0 * (1.0 + $cos(PI * real'(k) / 32.0)) + 0.5));
  endfunction

  function automatic longint scale_of(longint s, int k);
    if (k == 0) return s;
    if (k >= NSTEP) return 0;
    return (s * gain_of(k) + 64'sd32768) >>> 16;
  endfunction

  // behavioural reference, advanced on every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_vld = 1'b0;
      for (int ch = 0; ch < 2; ch++) begin
        m_out[ch] = 0; m_idx[ch] = 0; m_cnt[ch] = 0; m_dir[ch] = 1'b0;
      end
      m_held[0] = 2;
      m_held[1] = 1;
    end else begin
      m_vld = vld;
      if (vld) begin
        for (int ch = 0; ch < 2; ch++) begin
          int     code, sel, base, straight;
          bit     mute, moving;
          longint s, sl, sr;
          sl = longint'($signed(l_in));
          sr = longint'($signed(r_in));
          straight = (ch == 0) ? 2 : 1;
          code = regm ? int'((ch == 0) ? cl : cr) : straight;
          mute = regm ? (code == 0) : ((ch == 0) ? pml : pmr);
          sel  = (code == 0) ? m_held[ch] : code;
          if (sel == 1) s = sr;
          else if (sel == 2) s = sl;
          else s = (sl + sr) >>> 1;
          m_out[ch] = scale_of(s, m_idx[ch]);
          if (code != 0) m_held[ch] = code;
          base = (mute != m_dir[ch]) ? 0 : m_cnt[ch];
          m_dir[ch] = mute;
          moving = mute ? (m_idx[ch] < NSTEP) : (m_idx[ch] > 0);
          if (!moving) m_cnt[ch] = 0;
          else if (base == HOLD - 1) begin
            m_cnt[ch] = 0;
            m_idx[ch] = m_idx[ch] + (mute ? 1 : -1);
          end else m_cnt[ch] = base + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      vectors++;
      if (vld_o !== m_vld) begin
        misses++;
        $display("FAIL %s strobe got %0b exp %0b", tag, vld_o, m_vld);
      end
      if (longint'($signed(l_o)) != m_out[0]) begin
        misses++;
        $display("FAIL %s left got %0d exp %0d", tag, $signed(l_o), m_out[0]);
      end
      if (longint'($signed(r_o)) != m_out[1]) begin
        misses++;
        $display("FAIL %s right got %0d exp %0d", tag, $signed(r_o), m_out[1]);
      end
    end
  end

  task automatic tick(input bit v);
    @(posedge clk); #2;
    seed = seed * 32'd1103515245 + 32'd12345;
    l_in = seed[31:12];
    seed = seed * 32'd1103515245 + 32'd12345;
    r_in = seed[31:12];
    vld  = v;
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tick(1'b1);
      for (int g = 0; g < gap; g++) tick(1'b0);
    end
  endtask

  task automatic put(input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(posedge clk); #2;
    l_in = a; r_in = b; vld = 1'b1;
  endtask

  initial begin
    // R11: reset state
    repeat (2) @(posedge clk);
    #2 chk_en = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 R3: every routing pair, random and extreme samples
    tag = "R1 R3";
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        cl = 2'(a); cr = 2'(b);
        put(20'h7FFFF, 20'h7FFFF);
        put(20'h80000, 20'h80000);
        put(20'h80000, 20'h7FFFF);
        put(20'h00001, 20'hFFFFF);
        put(20'hFFFFF, 20'hFFFFE);
        run(6, 0);
      end
    end

    // R2 R8: sparse strobes
    tag = "R2 R8";
    cl = 2'b10; cr = 2'b11;
    run(40, 2);

    // R4 R10: full descent on left while holding the left source
    tag = "R4 R10";
    cl = 2'b10; run(4, 0);
    cl = 2'b00;
    run(1024, 0);
    tag = "R5";
    run(100, 1);
    tag = "R6";
    cl = 2'b10;
    run(1100, 0);

    // R10: right channel remembers the mean
    tag = "R10";
    cr = 2'b11; run(3, 0);
    cr = 2'b00; run(300, 0);
    cr = 2'b11; run(300, 0);

    // R7: reversals part-way through the ramp
    tag = "R7";
    cl = 2'b00; run(100, 0);
    cl = 2'b01; run(200, 0);
    cl = 2'b00; run(40, 0);
    cl = 2'b10; run(400, 0);

    // R9: pin mode ignores codes, pins mute their own channel
    tag = "R9";
    regm = 1'b0; cl = 2'b00; cr = 2'b00;
    run(50, 0);
    pmr = 1'b1; run(1100, 0);
    pml = 1'b1; pmr = 1'b0; run(600, 0);
    pml = 1'b0; run(1100, 0);
    cl = 2'b11; cr = 2'b10; run(30, 1);

    tag = "R1 R2";
    regm = 1'b1; cl = 2'b10; cr = 2'b01;
    run(20, 0);
    repeat (3) tick(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1500000;
    misses++;
    $display("FAIL %s watchdog got timeout exp completion", tag);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule